// File: doc/BRIEF.md
# On-chip data space router

This block sits between an 8051-style core's operand path and its internal data space. The space has 256 bytes of RAM and a special-function-register (SFR) bus. The lower half of the address range is plain RAM. The upper half is shared by two separate targets: the upper 128 bytes of RAM and the SFR bus. The addressing mode of the access decides which of the two is used. Direct accesses above 7FH go to the SFR bus. Indirect accesses above 7FH go to upper RAM. Stack pushes and pops count as indirect, so the stack can sit in upper RAM.

The core presents an address, a mode bit, read and write strobes and write data. The block drives three combinational select lines: lower RAM, upper RAM and SFR. It forwards SFR accesses to an external register port, which answers with read data and a hit flag. The RAM is held in two banks of equal size. Read data is registered, so it appears in the cycle after the read strobe.

A small state register records which target the last read went to: none, lower bank, upper bank or SFR. States and transitions: every cycle the state moves to NONE when rd_en is low. When rd_en is high, the next state is LO for an address below 80H, HI for an indirect upper address, and SFR for a direct upper address. The output stage reads the state to pick the source of rdata.

Top module: `dspace_router`

## Requirements
- R1: When a strobe is active and the address is 00H–7FH, only sel_lo is high, in either mode, and sfr_rd and sfr_wr stay low.
- R2: A direct-mode access (mode_ind=0) to 80H–FFH raises only sel_sfr. The access is forwarded with sfr_addr equal to addr; sfr_rd follows rd_en.
- R3: An indirect-mode access (mode_ind=1) to 80H–FFH raises only sel_hi and never drives sfr_rd or sfr_wr, even when sfr_hit is high.
- R4: A stack-style indirect write followed by an indirect read at the same upper address returns the written byte. A direct SFR write to that address leaves the stored byte unchanged.
- R5: rdata shows the byte read at one clock edge after that edge, until the next edge. After an edge with rd_en low, rdata is 00H.
- R6: When rd_en and wr_en are both high for one address, rdata returns the old byte, and the new byte is stored.
- R7: A direct SFR access with sfr_hit low reads back 00H and does not assert sfr_wr.
- R8: A direct SFR read with sfr_hit high returns the value of sfr_rdata sampled at the read edge.
- R9: After reset, rdata is 00H. With no strobe active, all select and SFR strobe outputs are low.
- R10: At most one of sel_lo, sel_hi and sel_sfr is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Data-space address |
| mode_ind | input | 1 | 1 = indirect (including stack), 0 = direct |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sel_lo | output | 1 | Access targets lower RAM |
| sel_hi | output | 1 | Access targets upper RAM |
| sel_sfr | output | 1 | Access targets SFR bus |
| sfr_addr | output | 8 | SFR bus address |
| sfr_rd | output | 1 | SFR read strobe |
| sfr_wr | output | 1 | SFR write strobe, implemented registers only |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data from the register bank |
| sfr_hit | input | 1 | Register bank has a register at sfr_addr |

## Verification
The bench writes to address A0H through both targets and reads it back both ways. A router that ignored the mode bit would return the SFR value from RAM, or the reverse. The 7FH/80H boundary is exercised so that an off-by-one in the decode sends a lower-RAM byte to the SFR bus. A read and a write to the same address in the same cycle must return the old byte; a write-first RAM would return the new one. Unimplemented SFR reads must give 00H and no write strobe, and idle cycles must clear rdata. A stale output stage would show through in either of these cases.

// File: rtl/dspace_pkg.sv
package dspace_pkg;
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LO   = 2'd1,
        SRC_HI   = 2'd2,
        SRC_SFR  = 2'd3
    } dsp_src_e;
endpackage

// File: rtl/dspace_decode.sv
module dspace_decode
    import dspace_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic [AW-1:0] addr,
    input  logic          mode_ind,
    input  logic          active,
    output dsp_src_e      target
);
    always_comb begin
        if (!active)
            target = SRC_NONE;
        else if (!addr[AW-1])
            target = SRC_LO;
        else if (mode_ind)
            target = SRC_HI;
        else
            target = SRC_SFR;
    end
endmodule

// File: rtl/dspace_bank.sv
module dspace_bank #(
    parameter int BAW = 7,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           we,
    input  logic           re,
    input  logic [BAW-1:0] a,
    input  logic [DW-1:0]  d,
    output logic [DW-1:0]  q
);
    localparam int DEPTH = 1 << BAW;

    logic [DW-1:0] mem [DEPTH];

    // Read-before-write: q takes the old word when both enables hit one address.
    always_ff @(posedge clk) begin
        if (we) mem[a] <= d;
        if (re) q <= mem[a];
    end
endmodule

// File: rtl/dspace_router.sv
module dspace_router
    import dspace_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          mode_ind,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          sel_lo,
    output logic          sel_hi,
    output logic          sel_sfr,
    output logic [AW-1:0] sfr_addr,
    output logic          sfr_rd,
    output logic          sfr_wr,
    output logic [DW-1:0] sfr_wdata,
    input  logic [DW-1:0] sfr_rdata,
    input  logic          sfr_hit
);
    localparam int BAW    = AW - 1;
    localparam int NBANK  = 2;

    dsp_src_e      target;
    dsp_src_e      state_q, state_d;
    logic [DW-1:0] bank_q [NBANK];
    logic [DW-1:0] sfr_q;
    logic [NBANK-1:0] bank_sel;

    dspace_decode #(.AW(AW)) u_decode (
        .addr     (addr),
        .mode_ind (mode_ind),
        .active   (rd_en | wr_en),
        .target   (target)
    );

    assign sel_lo    = (target == SRC_LO);
    assign sel_hi    = (target == SRC_HI);
    assign sel_sfr   = (target == SRC_SFR);
    assign bank_sel  = {sel_hi, sel_lo};
    assign sfr_addr  = addr;
    assign sfr_wdata = wdata;
    assign sfr_rd    = sel_sfr & rd_en;
    assign sfr_wr    = sel_sfr & wr_en & sfr_hit;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        dspace_bank #(.BAW(BAW), .DW(DW)) u_bank (
            .clk (clk),
            .we  (wr_en & bank_sel[g]),
            .re  (rd_en & bank_sel[g]),
            .a   (addr[BAW-1:0]),
            .d   (wdata),
            .q   (bank_q[g])
        );
    end

    // Next-state: which source the registered read data comes from.
    always_comb begin
        state_d = rd_en ? target : SRC_NONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SRC_NONE;
            sfr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en && target == SRC_SFR)
                sfr_q <= sfr_hit ? sfr_rdata : '0;
        end
    end

    // Output stage selected by the state.
    always_comb begin
        unique case (state_q)
            SRC_NONE: rdata = '0;
            SRC_LO:   rdata = bank_q[0];
            SRC_HI:   rdata = bank_q[1];
            SRC_SFR:  rdata = sfr_q;
            default:  rdata = '0;
        endcase
    end

    p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_lo, sel_hi, sel_sfr}));

    p_low_ram_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_en || wr_en) && !addr[AW-1]) |-> (sel_lo && !sfr_rd && !sfr_wr));

    p_ind_no_sfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_ind |-> (!sfr_rd && !sfr_wr));

    p_unimpl_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_wr |-> sfr_hit);

    p_idle_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));
endmodule

// File: tb/test_dspace_router.sv
module test_dspace_router;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] addr = '0;
    logic       mode_ind = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sel_lo, sel_hi, sel_sfr;
    logic [7:0] sfr_addr, sfr_wdata;
    logic       sfr_rd, sfr_wr;
    logic [7:0] sfr_rdata = '0;
    logic       sfr_hit = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dspace_router i_dspace_router (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mode_ind(mode_ind),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .sel_lo(sel_lo), .sel_hi(sel_hi), .sel_sfr(sel_sfr),
        .sfr_addr(sfr_addr), .sfr_rd(sfr_rd), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .sfr_hit(sfr_hit)
    );

    // Fields: ind, rd, wr, addr, wdata, hit, sfr_rdata, exp_rdata, exp_sel{lo,hi,sfr}
    localparam logic [38:0] VEC [NVEC] = '{
        {1'b0,1'b0,1'b1,8'h10,8'hAA,1'b0,8'h00,8'h00,3'b100}, // R1 direct write low
        {1'b1,1'b0,1'b1,8'hA0,8'h55,1'b0,8'h00,8'h00,3'b010}, // R3 indirect write upper
        {1'b0,1'b0,1'b1,8'hA0,8'h77,1'b1,8'h00,8'h00,3'b001}, // R2 direct SFR write
        {1'b0,1'b1,1'b0,8'h10,8'h00,1'b0,8'h00,8'hAA,3'b100}, // R1 direct read low
        {1'b1,1'b1,1'b0,8'h10,8'h00,1'b0,8'h00,8'hAA,3'b100}, // R1 indirect read low
        {1'b1,1'b1,1'b0,8'hA0,8'h00,1'b1,8'h3C,8'h55,3'b010}, // R4 upper RAM untouched by SFR write
        {1'b0,1'b1,1'b0,8'hA0,8'h00,1'b1,8'h3C,8'h3C,3'b001}, // R8 implemented SFR read
        {1'b0,1'b1,1'b0,8'hA0,8'h00,1'b0,8'h3C,8'h00,3'b001}, // R7 unimplemented SFR read
        {1'b1,1'b0,1'b1,8'hFF,8'h81,1'b0,8'h00,8'h00,3'b010}, // R4 push to top
        {1'b1,1'b1,1'b0,8'hFF,8'h00,1'b0,8'h00,8'h81,3'b010}, // R4 pop from top
        {1'b0,1'b1,1'b1,8'h10,8'h11,1'b0,8'h00,8'hAA,3'b100}, // R6 read+write returns old
        {1'b0,1'b1,1'b0,8'h10,8'h00,1'b0,8'h00,8'h11,3'b100}, // R6 new byte stored
        {1'b1,1'b0,1'b1,8'h7F,8'h7E,1'b1,8'h00,8'h00,3'b100}, // R1 boundary 7FH indirect
        {1'b0,1'b1,1'b0,8'h7F,8'h00,1'b1,8'h99,8'h7E,3'b100}, // R1 boundary 7FH direct
        {1'b1,1'b1,1'b0,8'h80,8'h00,1'b1,8'h99,8'h00,3'b010}, // R10 boundary 80H upper (unwritten: sel only)
        {1'b0,1'b0,1'b0,8'h80,8'h00,1'b0,8'h00,8'h00,3'b000}  // R5 idle clears rdata
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic ind, input logic rd, input logic wr,
                         input logic [7:0] a, input logic [7:0] d,
                         input logic hit, input logic [7:0] sd);
        @(negedge clk);
        mode_ind = ind; rd_en = rd; wr_en = wr; addr = a; wdata = d;
        sfr_hit = hit; sfr_rdata = sd;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R9 reset rdata", {24'h0, rdata}, 32'h0);
        chk("R9 reset selects", {26'h0, sel_lo, sel_hi, sel_sfr, sfr_rd, sfr_wr, 1'b0}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][38], VEC[i][37], VEC[i][36], VEC[i][35:28],
                  VEC[i][27:20], VEC[i][19], VEC[i][18:11]);
            #1;
            chk($sformatf("R10 vector %0d selects", i),
                {29'h0, sel_lo, sel_hi, sel_sfr}, {29'h0, VEC[i][2:0]});
            @(negedge clk);
            if (i != 14)
                chk($sformatf("R5 vector %0d rdata", i), {24'h0, rdata}, {24'h0, VEC[i][10:3]});
        end

        // R2: direct SFR write to implemented register forwards strobe and data
        drive(1'b0, 1'b0, 1'b1, 8'h90, 8'h5A, 1'b1, 8'h00);
        #1;
        chk("R2 sfr_wr", {31'h0, sfr_wr}, 32'h1);
        chk("R2 sfr addr/data", {16'h0, sfr_addr, sfr_wdata}, 32'h905A);
        // R7: unimplemented SFR write not forwarded
        drive(1'b0, 1'b0, 1'b1, 8'h91, 8'h5A, 1'b0, 8'h00);
        #1;
        chk("R7 sfr_wr blocked", {31'h0, sfr_wr}, 32'h0);
        // R3: indirect upper access never strobes SFR even with hit
        drive(1'b1, 1'b1, 1'b1, 8'h90, 8'h22, 1'b1, 8'h00);
        #1;
        chk("R3 no sfr strobes", {30'h0, sfr_rd, sfr_wr}, 32'h0);
        // R2: direct SFR read strobe
        drive(1'b0, 1'b1, 1'b0, 8'h90, 8'h00, 1'b1, 8'hC3);
        #1;
        chk("R2 sfr_rd", {31'h0, sfr_rd}, 32'h1);
        @(negedge clk);
        chk("R8 sfr read data", {24'h0, rdata}, 32'hC3);
        // R4: upper RAM at 90H holds indirect byte, not SFR data
        drive(1'b1, 1'b1, 1'b0, 8'h90, 8'h00, 1'b1, 8'hC3);
        @(negedge clk);
        chk("R4 upper RAM 90H", {24'h0, rdata}, 32'h22);
        // R5: rdata held then cleared
        drive(1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00);
        @(negedge clk);
        chk("R5 idle clears", {24'h0, rdata}, 32'h0);
        chk("R9 idle selects", {29'h0, sel_lo, sel_hi, sel_sfr}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule